// File: doc/BRIEF.md
# Protection Region Configuration Registers

This block keeps the settings of a set of memory protection regions, split into instruction regions and data regions, and exposes them to software through two staging registers: a base register and an access register. Software first writes the base register with the region type, the region index and the start address (in units of the minimum region size). It then writes the access register with the permission code, the memory type, the size field and one command flag. The write flag copies the staged settings into the chosen slot. The read flag copies the chosen slot back into the staging registers, where software can read them.

Every stored slot is also driven out in parallel, on one flat vector per field and per region type, so that an address checker can compare against all regions at once. A build-time option picks whether the size field is a mask (region size) or a limit (the first address past the region, in minimum-region units). The limit variant needs one extra bit. The control register width is therefore the address width plus one in that case. The layout requires the minimum-region exponent to be at least 7 and larger than the index width.

Top module: `prot_region_cfg`

## Requirements
- R1: A synchronous reset clears every slot field on the parallel outputs, both staging registers and the read data to zero.
- R2: The base register keeps the type flag in bit 0 (1 = data, 0 = instruction), the index in bits [IDX_W:1] and the start field in bits [ADDR_W-1:MIN_LOG2]. Every other bit reads back as zero, whatever value was written to it.
- R3: The access register holds the write command in bit 0, the read command in bit 1, the permission code in bits [4:2], the memory type in bits [6:5] and the size field in bits [MIN_LOG2+SZ_W-1:MIN_LOG2]. SZ_W is ADDR_W-MIN_LOG2, plus one bit in the limit variant. Both command bits and all other bits read back as zero.
- R4: An access-register write with only the write flag set stores four values into the slot selected by the staged type and index: the staged start field, and the size, memory type and permission carried by that same write. The new values appear on the parallel outputs one cycle later, and every other slot keeps its value.
- R5: An access-register write with only the read flag set loads the selected slot's start field into the base register, and its size, memory type and permission into the access register. The loaded values replace the fields carried by the write. The staged type and index do not change.
- R6: An access-register write with both flags set changes no slot and loads nothing. The fields carried by the write are kept in the access register.
- R7: If the staged index is not below the number of regions of the staged type, a command changes no slot and loads nothing. The fields carried by the write are kept in the access register.
- R8: Slot k of each type appears at bits [k*W +: W] of that type's output vector for each field, where W is the field width.
- R9: The read data shows, one cycle later, the register chosen by csr_sel in the previous cycle: 0 selects the base register and 1 selects the access register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe for the selected staging register |
| csr_sel | input | 1 | Register select: 0 base, 1 access |
| csr_wdata | input | ADDR_W+USE_LIMIT | Write data |
| csr_rdata | output | ADDR_W+USE_LIMIT | Registered read data |
| inst_base_o | output | N_INST*BASE_W | Start fields of all instruction slots |
| inst_size_o | output | N_INST*SZ_W | Size fields of all instruction slots |
| inst_perm_o | output | N_INST*3 | Permission codes of all instruction slots |
| inst_mt_o | output | N_INST*2 | Memory types of all instruction slots |
| data_base_o | output | N_DATA*BASE_W | Start fields of all data slots |
| data_size_o | output | N_DATA*SZ_W | Size fields of all data slots |
| data_perm_o | output | N_DATA*3 | Permission codes of all data slots |
| data_mt_o | output | N_DATA*2 | Memory types of all data slots |

## Verification
A single access-register write can carry new field values and, at the same time, ask for a slot to be loaded into those same fields. The two updates then land at the same clock edge. The bench provokes this by sending read commands whose write data holds filler values in the size, memory type and permission fields. After each such command it reads back both registers. The slot contents must win, unless the index is out of range or both flags are set; in those cases the filler fields must remain and no slot may change.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int FLAG_WR_BIT = 0;
  localparam int FLAG_RD_BIT = 1;
  localparam int PERM_LSB    = 2;
  localparam int PERM_W      = 3;
  localparam int MT_LSB      = 5;
  localparam int MT_W        = 2;
  localparam int TYPE_BIT    = 0;
  localparam int IDX_LSB     = 1;

  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_ACC  = 1'b1
  } csr_sel_e;
endpackage

// File: rtl/prc_slot_bank.sv
module prc_slot_bank
  import prc_pkg::*;
#(
  parameter int N      = 4,
  parameter int BASE_W = 24,
  parameter int SZ_W   = 24,
  parameter int IDX_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      idx,
  input  logic [BASE_W-1:0]     wr_base,
  input  logic [SZ_W-1:0]       wr_size,
  input  logic [PERM_W-1:0]     wr_perm,
  input  logic [MT_W-1:0]       wr_mt,
  output logic [BASE_W-1:0]     rd_base,
  output logic [SZ_W-1:0]       rd_size,
  output logic [PERM_W-1:0]     rd_perm,
  output logic [MT_W-1:0]       rd_mt,
  output logic [N*BASE_W-1:0]   flat_base,
  output logic [N*SZ_W-1:0]     flat_size,
  output logic [N*PERM_W-1:0]   flat_perm,
  output logic [N*MT_W-1:0]     flat_mt
);
  localparam logic [IDX_W:0] N_L = (IDX_W+1)'(N);

  logic [BASE_W-1:0] base_mem [N];
  logic [SZ_W-1:0]   size_mem [N];
  logic [PERM_W-1:0] perm_mem [N];
  logic [MT_W-1:0]   mt_mem   [N];
  logic              in_range;

  assign in_range = ({1'b0, idx} < N_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) begin
        base_mem[k] <= '0;
        size_mem[k] <= '0;
        perm_mem[k] <= '0;
        mt_mem[k]   <= '0;
      end
    end else if (wr_en && in_range) begin
      base_mem[idx] <= wr_base;
      size_mem[idx] <= wr_size;
      perm_mem[idx] <= wr_perm;
      mt_mem[idx]   <= wr_mt;
    end
  end

  always_comb begin
    rd_base = '0;
    rd_size = '0;
    rd_perm = '0;
    rd_mt   = '0;
    if (in_range) begin
      rd_base = base_mem[idx];
      rd_size = size_mem[idx];
      rd_perm = perm_mem[idx];
      rd_mt   = mt_mem[idx];
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_flat
    assign flat_base[k*BASE_W +: BASE_W] = base_mem[k];
    assign flat_size[k*SZ_W +: SZ_W]     = size_mem[k];
    assign flat_perm[k*PERM_W +: PERM_W] = perm_mem[k];
    assign flat_mt[k*MT_W +: MT_W]       = mt_mem[k];
  end

  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_range) |=> (base_mem[$past(idx)] == $past(wr_base)) &&
                            (size_mem[$past(idx)] == $past(wr_size)) &&
                            (perm_mem[$past(idx)] == $past(wr_perm)) &&
                            (mt_mem[$past(idx)] == $past(wr_mt))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(flat_base) && $stable(flat_size) &&
               $stable(flat_perm) && $stable(flat_mt)); // R4
endmodule

// File: rtl/prc_csr.sv
module prc_csr
  import prc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 8,
  parameter int IDX_W    = 2,
  parameter int BASE_W   = 24,
  parameter int SZ_W     = 24,
  parameter int CSR_W    = 32,
  parameter int N_INST   = 4,
  parameter int N_DATA   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               csr_we,
  input  logic               csr_sel,
  input  logic [CSR_W-1:0]   csr_wdata,
  output logic [CSR_W-1:0]   csr_rdata,
  output logic               commit_inst,
  output logic               commit_data,
  output logic               cur_type,
  output logic [IDX_W-1:0]   cur_idx,
  output logic [BASE_W-1:0]  stage_base,
  output logic [SZ_W-1:0]    new_size,
  output logic [PERM_W-1:0]  new_perm,
  output logic [MT_W-1:0]    new_mt,
  input  logic [BASE_W-1:0]  ird_base,
  input  logic [SZ_W-1:0]    ird_size,
  input  logic [PERM_W-1:0]  ird_perm,
  input  logic [MT_W-1:0]    ird_mt,
  input  logic [BASE_W-1:0]  drd_base,
  input  logic [SZ_W-1:0]    drd_size,
  input  logic [PERM_W-1:0]  drd_perm,
  input  logic [MT_W-1:0]    drd_mt
);
  localparam logic [IDX_W:0] NI_L = (IDX_W+1)'(N_INST);
  localparam logic [IDX_W:0] ND_L = (IDX_W+1)'(N_DATA);

  logic              type_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BASE_W-1:0] base_q;
  logic [SZ_W-1:0]   size_q;
  logic [PERM_W-1:0] perm_q;
  logic [MT_W-1:0]   mt_q;
  logic [CSR_W-1:0]  rdata_q;
  logic [CSR_W-1:0]  base_word, acc_word;

  logic              acc_wr, flag_wr, flag_rd, idx_ok, do_commit, do_load;
  logic [BASE_W-1:0] rd_base;
  logic [SZ_W-1:0]   rd_size;
  logic [PERM_W-1:0] rd_perm;
  logic [MT_W-1:0]   rd_mt;
  logic              unused_bits;

  assign unused_bits = ^csr_wdata;

  assign acc_wr    = csr_we && (csr_sel == SEL_ACC);
  assign flag_wr   = csr_wdata[FLAG_WR_BIT];
  assign flag_rd   = csr_wdata[FLAG_RD_BIT];
  assign idx_ok    = type_q ? ({1'b0, idx_q} < ND_L) : ({1'b0, idx_q} < NI_L);
  assign do_commit = acc_wr && flag_wr && !flag_rd && idx_ok;
  assign do_load   = acc_wr && flag_rd && !flag_wr && idx_ok;

  assign new_size = csr_wdata[MIN_LOG2 +: SZ_W];
  assign new_perm = csr_wdata[PERM_LSB +: PERM_W];
  assign new_mt   = csr_wdata[MT_LSB +: MT_W];

  assign rd_base = type_q ? drd_base : ird_base;
  assign rd_size = type_q ? drd_size : ird_size;
  assign rd_perm = type_q ? drd_perm : ird_perm;
  assign rd_mt   = type_q ? drd_mt   : ird_mt;

  always_comb begin
    base_word = '0;
    base_word[TYPE_BIT] = type_q;
    base_word[IDX_LSB +: IDX_W] = idx_q;
    base_word[MIN_LOG2 +: BASE_W] = base_q;
    acc_word = '0;
    acc_word[PERM_LSB +: PERM_W] = perm_q;
    acc_word[MT_LSB +: MT_W] = mt_q;
    acc_word[MIN_LOG2 +: SZ_W] = size_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q  <= 1'b0;
      idx_q   <= '0;
      base_q  <= '0;
      size_q  <= '0;
      perm_q  <= '0;
      mt_q    <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= (csr_sel == SEL_ACC) ? acc_word : base_word;
      if (csr_we && (csr_sel == SEL_BASE)) begin
        type_q <= csr_wdata[TYPE_BIT];
        idx_q  <= csr_wdata[IDX_LSB +: IDX_W];
        base_q <= csr_wdata[MIN_LOG2 +: BASE_W];
      end
      if (do_load) begin
        base_q <= rd_base;
        size_q <= rd_size;
        perm_q <= rd_perm;
        mt_q   <= rd_mt;
      end else if (acc_wr) begin
        size_q <= new_size;
        perm_q <= new_perm;
        mt_q   <= new_mt;
      end
    end
  end

  assign csr_rdata   = rdata_q;
  assign commit_inst = do_commit && !type_q;
  assign commit_data = do_commit && type_q;
  assign cur_type    = type_q;
  assign cur_idx     = idx_q;
  assign stage_base  = base_q;

  AST_LOAD_OVERRIDES: assert property (@(posedge clk) disable iff (rst)
    do_load |=> (base_q == $past(rd_base)) && (size_q == $past(rd_size)) &&
                (perm_q == $past(rd_perm)) && (mt_q == $past(rd_mt))); // R5

  AST_SELECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    acc_wr |=> $stable(type_q) && $stable(idx_q)); // R5
endmodule

// File: rtl/prot_region_cfg.sv
module prot_region_cfg
  import prc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MIN_LOG2  = 8,
  parameter int N_INST    = 4,
  parameter int N_DATA    = 4,
  parameter int USE_LIMIT = 0,
  parameter int BASE_W    = ADDR_W - MIN_LOG2,
  parameter int SZ_W      = ADDR_W - MIN_LOG2 + USE_LIMIT
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          csr_we,
  input  logic                          csr_sel,
  input  logic [ADDR_W+USE_LIMIT-1:0]   csr_wdata,
  output logic [ADDR_W+USE_LIMIT-1:0]   csr_rdata,
  output logic [N_INST*BASE_W-1:0]      inst_base_o,
  output logic [N_INST*SZ_W-1:0]        inst_size_o,
  output logic [N_INST*3-1:0]           inst_perm_o,
  output logic [N_INST*2-1:0]           inst_mt_o,
  output logic [N_DATA*BASE_W-1:0]      data_base_o,
  output logic [N_DATA*SZ_W-1:0]        data_size_o,
  output logic [N_DATA*3-1:0]           data_perm_o,
  output logic [N_DATA*2-1:0]           data_mt_o
);
  localparam int CSR_W = ADDR_W + USE_LIMIT;
  localparam int MAXN  = (N_INST > N_DATA) ? N_INST : N_DATA;
  localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1;
  localparam logic [IDX_W:0] NI_L = (IDX_W+1)'(N_INST);
  localparam logic [IDX_W:0] ND_L = (IDX_W+1)'(N_DATA);

  logic              commit_inst, commit_data, cur_type;
  logic [IDX_W-1:0]  cur_idx;
  logic [BASE_W-1:0] stage_base, ird_base, drd_base;
  logic [SZ_W-1:0]   new_size, ird_size, drd_size;
  logic [PERM_W-1:0] new_perm, ird_perm, drd_perm;
  logic [MT_W-1:0]   new_mt, ird_mt, drd_mt;

  prc_csr #(
    .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .IDX_W(IDX_W), .BASE_W(BASE_W),
    .SZ_W(SZ_W), .CSR_W(CSR_W), .N_INST(N_INST), .N_DATA(N_DATA)
  ) u_csr (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .commit_inst(commit_inst), .commit_data(commit_data),
    .cur_type(cur_type), .cur_idx(cur_idx), .stage_base(stage_base),
    .new_size(new_size), .new_perm(new_perm), .new_mt(new_mt),
    .ird_base(ird_base), .ird_size(ird_size), .ird_perm(ird_perm), .ird_mt(ird_mt),
    .drd_base(drd_base), .drd_size(drd_size), .drd_perm(drd_perm), .drd_mt(drd_mt)
  );

  prc_slot_bank #(.N(N_INST), .BASE_W(BASE_W), .SZ_W(SZ_W), .IDX_W(IDX_W)) u_inst (
    .clk(clk), .rst(rst), .wr_en(commit_inst), .idx(cur_idx),
    .wr_base(stage_base), .wr_size(new_size), .wr_perm(new_perm), .wr_mt(new_mt),
    .rd_base(ird_base), .rd_size(ird_size), .rd_perm(ird_perm), .rd_mt(ird_mt),
    .flat_base(inst_base_o), .flat_size(inst_size_o),
    .flat_perm(inst_perm_o), .flat_mt(inst_mt_o)
  );

  prc_slot_bank #(.N(N_DATA), .BASE_W(BASE_W), .SZ_W(SZ_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rst(rst), .wr_en(commit_data), .idx(cur_idx),
    .wr_base(stage_base), .wr_size(new_size), .wr_perm(new_perm), .wr_mt(new_mt),
    .rd_base(drd_base), .rd_size(drd_size), .rd_perm(drd_perm), .rd_mt(drd_mt),
    .flat_base(data_base_o), .flat_size(data_size_o),
    .flat_perm(data_perm_o), .flat_mt(data_mt_o)
  );

  logic acc_cmd_wr, acc_cmd_both, idx_bad;
  assign acc_cmd_wr   = csr_we && csr_sel && csr_wdata[FLAG_WR_BIT];
  assign acc_cmd_both = acc_cmd_wr && csr_wdata[FLAG_RD_BIT];
  assign idx_bad      = cur_type ? ({1'b0, cur_idx} >= ND_L) : ({1'b0, cur_idx} >= NI_L);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (csr_rdata == '0) && (inst_base_o == '0) && (inst_size_o == '0) &&
                   (inst_perm_o == '0) && (inst_mt_o == '0) && (data_base_o == '0) &&
                   (data_size_o == '0) && (data_perm_o == '0) && (data_mt_o == '0)); // R1

  AST_FLAGS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(csr_sel) |-> (csr_rdata[1:0] == 2'b00)); // R3

  AST_BOTH_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    acc_cmd_both |=> $stable(inst_base_o) && $stable(inst_size_o) &&
                     $stable(data_base_o) && $stable(data_size_o) &&
                     $stable(inst_perm_o) && $stable(data_perm_o)); // R6

  AST_BAD_INDEX_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (acc_cmd_wr && idx_bad) |=> $stable(inst_base_o) && $stable(inst_size_o) &&
                                $stable(data_base_o) && $stable(data_size_o) &&
                                $stable(inst_mt_o) && $stable(data_mt_o)); // R7
endmodule

// File: tb/sim_prot_region_cfg.sv
`timescale 1ns/1ps
module sim_prot_region_cfg;
  localparam int AW = 16, ML = 8, NI = 2, ND = 3, UL = 1;
  localparam int BW = AW - ML;       // 8
  localparam int SW = AW - ML + UL;  // 9
  localparam int CW = AW + UL;       // 17

  logic clk = 1'b0, rst = 1'b1, csr_we = 1'b0, csr_sel = 1'b0;
  logic [CW-1:0] csr_wdata = '0, csr_rdata;
  logic [NI*BW-1:0] inst_base_o; logic [NI*SW-1:0] inst_size_o;
  logic [NI*3-1:0]  inst_perm_o; logic [NI*2-1:0]  inst_mt_o;
  logic [ND*BW-1:0] data_base_o; logic [ND*SW-1:0] data_size_o;
  logic [ND*3-1:0]  data_perm_o; logic [ND*2-1:0]  data_mt_o;

  int checks = 0, failures = 0;
  bit done = 0;
  int m_b [2][4], m_sz [2][4], m_pm [2][4], m_mt [2][4];

  always #4 clk = ~clk;

  prot_region_cfg #(.ADDR_W(AW), .MIN_LOG2(ML), .N_INST(NI), .N_DATA(ND), .USE_LIMIT(UL)) u0 (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .inst_base_o(inst_base_o), .inst_size_o(inst_size_o),
    .inst_perm_o(inst_perm_o), .inst_mt_o(inst_mt_o), .data_base_o(data_base_o),
    .data_size_o(data_size_o), .data_perm_o(data_perm_o), .data_mt_o(data_mt_o));

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  function automatic logic [CW-1:0] mk_base(int t, int i, int b);
    return CW'((b << ML) | (i << 1) | t);
  endfunction

  function automatic logic [CW-1:0] mk_acc(int sz, int mt, int pm, int rd, int wr);
    return CW'((sz << ML) | (mt << 5) | (pm << 2) | (rd << 1) | wr);
  endfunction

  task automatic csr_write(input logic s, input logic [CW-1:0] d);
    @(negedge clk); csr_we = 1'b1; csr_sel = s; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic s, output logic [CW-1:0] d);
    @(negedge clk); csr_we = 1'b0; csr_sel = s;
    @(posedge clk); @(negedge clk); d = csr_rdata;
  endtask

  // R8: slot k of each field vector at [k*W +: W]
  task automatic chk_slots(input string rq);
    for (int k = 0; k < NI; k++) begin
      chk({rq, " R8 ibase"}, 32'(inst_base_o[k*BW +: BW]), 32'(m_b[0][k]));
      chk({rq, " R8 isize"}, 32'(inst_size_o[k*SW +: SW]), 32'(m_sz[0][k]));
      chk({rq, " R8 iperm"}, 32'(inst_perm_o[k*3 +: 3]), 32'(m_pm[0][k]));
      chk({rq, " R8 imt"},   32'(inst_mt_o[k*2 +: 2]), 32'(m_mt[0][k]));
    end
    for (int k = 0; k < ND; k++) begin
      chk({rq, " R8 dbase"}, 32'(data_base_o[k*BW +: BW]), 32'(m_b[1][k]));
      chk({rq, " R8 dsize"}, 32'(data_size_o[k*SW +: SW]), 32'(m_sz[1][k]));
      chk({rq, " R8 dperm"}, 32'(data_perm_o[k*3 +: 3]), 32'(m_pm[1][k]));
      chk({rq, " R8 dmt"},   32'(data_mt_o[k*2 +: 2]), 32'(m_mt[1][k]));
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] rd;
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 4; i++) begin
        m_b[t][i] = 0; m_sz[t][i] = 0; m_pm[t][i] = 0; m_mt[t][i] = 0;
      end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    csr_read(1'b0, rd); chk("R1 base reg", 32'(rd), 0);
    csr_read(1'b1, rd); chk("R1 acc reg", 32'(rd), 0);
    chk_slots("R1");

    // Commit sweep with junk in unused bits (gap bits 7:3 and bit 16 of base, bit 7 of access)
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 4; i++) begin
        int b, sz, pm, mt;
        bit ok;
        b  = (t * 64 + i * 13 + 5) & 255;
        sz = (t * 200 + i * 37 + 1) & 511;
        pm = (i + 3 * t + 1) % 8;
        mt = (i + t) % 4;
        ok = (i < (t ? ND : NI));
        csr_write(1'b0, mk_base(t, i, b) | CW'(17'h100F8));
        csr_read(1'b0, rd); chk("R2 base readback", 32'(rd), 32'(mk_base(t, i, b)));
        csr_write(1'b1, mk_acc(sz, mt, pm, 0, 1) | CW'(17'h00080));
        if (ok) begin
          m_b[t][i] = b; m_sz[t][i] = sz; m_pm[t][i] = pm; m_mt[t][i] = mt;
        end
        csr_read(1'b1, rd); chk("R3 R9 acc readback", 32'(rd), 32'(mk_acc(sz, mt, pm, 0, 0)));
        chk_slots(ok ? "R4" : "R7");
      end

    // Load sweep: filler fields in the command must be replaced by slot contents
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 4; i++) begin
        bit ok;
        ok = (i < (t ? ND : NI));
        csr_write(1'b0, mk_base(t, i, 8'hAA));
        csr_write(1'b1, mk_acc(9'h1FF, 3, 7, 1, 0));
        csr_read(1'b0, rd);
        if (ok) chk("R5 load base", 32'(rd), 32'(mk_base(t, i, m_b[t][i])));
        else    chk("R7 no load base", 32'(rd), 32'(mk_base(t, i, 8'hAA)));
        csr_read(1'b1, rd);
        if (ok) chk("R5 load acc", 32'(rd), 32'(mk_acc(m_sz[t][i], m_mt[t][i], m_pm[t][i], 0, 0)));
        else    chk("R7 no load acc", 32'(rd), 32'(mk_acc(9'h1FF, 3, 7, 0, 0)));
        chk_slots("R5");
      end

    // Both flags: no commit, no load
    csr_write(1'b0, mk_base(1, 1, 8'h55));
    csr_write(1'b1, mk_acc(9'h0AB, 2, 5, 1, 1));
    chk_slots("R6");
    csr_read(1'b0, rd); chk("R6 base kept", 32'(rd), 32'(mk_base(1, 1, 8'h55)));
    csr_read(1'b1, rd); chk("R6 acc fields", 32'(rd), 32'(mk_acc(9'h0AB, 2, 5, 0, 0)));

    // Overwrite one instruction slot and confirm neighbours stay
    csr_write(1'b0, mk_base(0, 1, 8'h3C));
    csr_write(1'b1, mk_acc(9'h100, 1, 2, 0, 1));
    m_b[0][1] = 8'h3C; m_sz[0][1] = 9'h100; m_mt[0][1] = 1; m_pm[0][1] = 2;
    chk_slots("R4 rewrite");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule